// File: doc/BRIEF.md
# Masked-Clear Latched Status Register Bank

This block keeps a set of 8-bit status registers for a host-controlled framer. Each register position is either an event bit or a condition bit. An event bit is sticky: it goes high on a one-cycle event pulse and stays high until the host collects it. A condition bit always shows the live level of its input and keeps no history. Each status register has an interrupt mask register beside it. One active-low interrupt line reports whether any enabled event bit is pending.

The host uses a plain clocked strobe bus with an address, a write strobe, a read strobe and data in both directions. There is no back-pressure: every strobe is taken in the cycle it is seen. A write to a status register never stores the written byte. The byte tells the block which event bits to collect. Each chosen bit is copied into a per-register read-holding register and then cleared. A bit that is not chosen keeps its earlier copy and its sticky state. The read that follows returns the holding register for event positions and the live level for condition positions. Because events can arrive in the middle of this exchange, the host may send a second write of (read value AND mask). That write follows the same collect-and-clear rule.

Top module: `evt_status_bank`

## Requirements
- R1: An event pulse on an event position sets that sticky bit at the next clock edge. The bit stays set, with no further pulse, until a write selects it.
- R2: A write to status register k (address k, 0 to NREG-1) with a 1 in an event position copies that position's current sticky value into the read-holding register and clears the sticky bit.
- R3: A 0 in a write's mask byte leaves that position's read-holding bit and its sticky bit unchanged. The written byte is never stored as data.
- R4: When the read strobe is high in a cycle, bus_rdata shows the addressed register from the next clock edge on and keeps that value until the next read. Status reads return the holding bit at event positions and the live rt_cond level at condition positions.
- R5: Condition positions (LATCH_BITS bit = 0) never latch, ignore event pulses and mask writes, and never drive the interrupt.
- R6: If an event pulse and a selecting write hit the same position in the same cycle, the sticky bit stays set. The holding bit takes the value from before that edge.
- R7: Interrupt mask register k sits at address NREG+k. It is a plain read/write register that resets to 0. A 1 enables the matching event position onto the interrupt.
- R8: irq_n is low exactly while some event position has both its sticky bit and its mask bit at 1. It goes low the cycle after the causing pulse or mask write, and returns high the cycle after the last such bit is cleared.
- R9: Reset clears all sticky bits, holding registers, mask registers and bus_rdata, and drives irq_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (3) | Register address: status 0..NREG-1, masks NREG..2*NREG-1 |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | DW (8) | Collect mask for status registers; data for mask registers |
| bus_rdata | output | DW (8) | Registered read data |
| evt_pulse | input | NREG*DW | One-cycle event pulses, byte k for register k |
| rt_cond | input | NREG*DW | Live condition levels, byte k for register k |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with four registers of eight bits. It uses a LATCH_BITS value that gives each register a different split: a low nibble of event bits, all event bits, six event bits and seven event bits. With this split one stimulus can hit event and condition positions of the same byte, so a read shows whether the holding path and the live path were merged at the right bit positions. It also lets the bench enable a condition position in a mask register and confirm that the interrupt stays high.

// File: rtl/sbk_pkg.sv
package sbk_pkg;
  typedef enum logic {
    REGION_STATUS = 1'b0,
    REGION_MASK   = 1'b1
  } region_e;

  function automatic int unsigned addr_bits(int unsigned nreg);
    return (2 * nreg > 1) ? $clog2(2 * nreg) : 1;
  endfunction
endpackage

// File: rtl/sbk_status_reg.sv
module sbk_status_reg #(
  parameter int            DW    = 8,
  parameter logic [DW-1:0] LBITS = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt,
  input  logic          sel_we,
  input  logic [DW-1:0] sel,
  output logic [DW-1:0] latch_q,
  output logic [DW-1:0] hold_q
);
  logic [DW-1:0] pick;

  // only event positions can be collected
  assign pick = sel_we ? (sel & LBITS) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      hold_q  <= '0;
    end else begin
      // a new pulse overrides the clear in the same cycle
      latch_q <= ((latch_q & ~pick) | evt) & LBITS;
      hold_q  <= (hold_q & ~pick) | (latch_q & pick);
    end
  end
endmodule

// File: rtl/sbk_mask_reg.sv
module sbk_mask_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/sbk_irq_merge.sv
module sbk_irq_merge #(
  parameter int NBITS = 32
) (
  input  logic [NBITS-1:0] pend,
  output logic             irq_n
);
  assign irq_n = ~(|pend);
endmodule

// File: rtl/evt_status_bank.sv
module evt_status_bank
  import sbk_pkg::*;
#(
  parameter int                 NREG       = 4,
  parameter int                 DW         = 8,
  parameter logic [NREG*DW-1:0] LATCH_BITS = '1,
  localparam int                AW         = addr_bits(NREG),
  localparam int                NB         = NREG * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NB-1:0] evt_pulse,
  input  logic [NB-1:0] rt_cond,
  output logic          irq_n
);
  logic [NB-1:0] latch_flat;
  logic [NB-1:0] hold_flat;
  logic [NB-1:0] mask_flat;
  logic [NB-1:0] pend_flat;
  logic [DW-1:0] rd_mux;
  region_e       rgn;

  assign rgn = (int'(bus_addr) >= NREG) ? REGION_MASK : REGION_STATUS;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic stat_we;
    logic mask_we;

    assign stat_we = bus_wr && (rgn == REGION_STATUS) && (int'(bus_addr) == k);
    assign mask_we = bus_wr && (rgn == REGION_MASK) && (int'(bus_addr) == NREG + k);

    sbk_status_reg #(
      .DW   (DW),
      .LBITS(LATCH_BITS[k*DW +: DW])
    ) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt_pulse[k*DW +: DW]),
      .sel_we (stat_we),
      .sel    (bus_wdata),
      .latch_q(latch_flat[k*DW +: DW]),
      .hold_q (hold_flat[k*DW +: DW])
    );

    sbk_mask_reg #(.DW(DW)) u_mask (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (mask_we),
      .wdata(bus_wdata),
      .q    (mask_flat[k*DW +: DW])
    );
  end

  // condition positions never reach the interrupt
  assign pend_flat = latch_flat & mask_flat & LATCH_BITS;

  sbk_irq_merge #(.NBITS(NB)) u_irq (
    .pend (pend_flat),
    .irq_n(irq_n)
  );

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NREG; k++) begin
      if (int'(bus_addr) == k)
        rd_mux = (hold_flat[k*DW +: DW] & LATCH_BITS[k*DW +: DW])
               | (rt_cond[k*DW +: DW] & ~LATCH_BITS[k*DW +: DW]);
      if (int'(bus_addr) == NREG + k)
        rd_mux = mask_flat[k*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/evt_status_bank_chk.sv
module evt_status_bank_chk #(
  parameter int                 NREG       = 4,
  parameter int                 DW         = 8,
  parameter logic [NREG*DW-1:0] LATCH_BITS = '1,
  parameter int                 AW         = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [DW-1:0]      bus_wdata,
  input logic [DW-1:0]      bus_rdata,
  input logic [NREG*DW-1:0] evt_pulse,
  input logic               irq_n,
  input logic [NREG*DW-1:0] latch_flat,
  input logic [NREG*DW-1:0] hold_flat,
  input logic [NREG*DW-1:0] mask_flat
);
  AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_pulse & LATCH_BITS)) |=> ((latch_flat & $past(evt_pulse & LATCH_BITS)) == $past(evt_pulse & LATCH_BITS))); // R1

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R4

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(mask_flat)); // R7

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n && !bus_wr && (evt_pulse == '0)) |=> irq_n); // R8

  for (genvar k = 0; k < NREG; k++) begin : g_chk
    AST_SEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (int'(bus_addr) == k)) |=> ((latch_flat[k*DW +: DW] & $past(bus_wdata & ~evt_pulse[k*DW +: DW])) == '0)); // R2

    AST_UNSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && (int'(bus_addr) == k)) |=> $stable(hold_flat[k*DW +: DW])); // R3

    AST_COLLIDE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (int'(bus_addr) == k) && (|(bus_wdata & evt_pulse[k*DW +: DW] & LATCH_BITS[k*DW +: DW])))
      |=> ((latch_flat[k*DW +: DW] & $past(bus_wdata & evt_pulse[k*DW +: DW] & LATCH_BITS[k*DW +: DW]))
           == $past(bus_wdata & evt_pulse[k*DW +: DW] & LATCH_BITS[k*DW +: DW]))); // R6
  end
endmodule

bind evt_status_bank evt_status_bank_chk #(
  .NREG(NREG), .DW(DW), .LATCH_BITS(LATCH_BITS), .AW(AW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse), .irq_n(irq_n),
  .latch_flat(latch_flat), .hold_flat(hold_flat), .mask_flat(mask_flat)
);

// File: tb/evt_status_bank_tb_top.sv
`timescale 1ns/1ps
module evt_status_bank_tb_top;
  localparam int               NREG = 4;
  localparam int               DW   = 8;
  localparam logic [NREG*DW-1:0] LB = 32'h7F3F_FF0F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [31:0] evt_pulse = '0;
  logic [31:0] rt_cond = '0;
  logic        irq_n;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  evt_status_bank #(.NREG(NREG), .DW(DW), .LATCH_BITS(LB)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
    .rt_cond(rt_cond), .irq_n(irq_n)
  );

  typedef struct packed {
    logic [1:0] r;
    logic [7:0] evt;
    logic [7:0] rt;
    logic [7:0] sel;
    logic [7:0] exp;
  } vec_t;

  // register, event byte, live byte, collect mask, expected read
  localparam vec_t VEC [8] = '{
    '{2'd1, 8'hA5, 8'h00, 8'hFF, 8'hA5},
    '{2'd1, 8'h5A, 8'hFF, 8'h0F, 8'hAA},
    '{2'd1, 8'h00, 8'h00, 8'hF0, 8'h5A},
    '{2'd0, 8'hFF, 8'hC3, 8'hFF, 8'hCF},
    '{2'd0, 8'h00, 8'h30, 8'hFF, 8'h30},
    '{2'd3, 8'h81, 8'h80, 8'h01, 8'h81},
    '{2'd2, 8'h3C, 8'h40, 8'h00, 8'h40},
    '{2'd2, 8'h00, 8'h00, 8'h3F, 8'h3C}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input int r, input logic [7:0] b);
    @(negedge clk);
    evt_pulse[r*8 +: 8] = b;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R9 rdata", bus_rdata, 8'h00);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) begin
      do_read(3'(a), rd);
      chk("R9 reset read", rd, 8'h00);
    end

    // R1 R2 R3 R4 R5: vector table
    for (int i = 0; i < 8; i++) begin
      rt_cond = '0;
      rt_cond[int'(VEC[i].r)*8 +: 8] = VEC[i].rt;
      pulse(int'(VEC[i].r), VEC[i].evt);
      do_write({1'b0, VEC[i].r}, VEC[i].sel);
      do_read({1'b0, VEC[i].r}, rd);
      chk($sformatf("R1 R2 R3 R4 R5 vector %0d", i), rd, VEC[i].exp);
    end
    rt_cond = '0;

    // R7: mask register read/write
    do_write(3'd6, 8'hA5);
    do_read(3'd6, rd);
    chk("R7 mask readback", rd, 8'hA5);
    do_write(3'd6, 8'h00);
    do_read(3'd6, rd);
    chk("R7 mask cleared", rd, 8'h00);

    // R8: masked event keeps irq high, enabling it pulls irq low
    pulse(1, 8'h04);
    chk("R8 masked event", {7'd0, irq_n}, 8'h01);
    do_write(3'd5, 8'h04);
    chk("R8 enabled event", {7'd0, irq_n}, 8'h00);
    do_write(3'd1, 8'h04);
    chk("R2 R8 clear releases irq", {7'd0, irq_n}, 8'h01);
    do_read(3'd1, rd);
    chk("R2 collected bit", rd, 8'h5E);

    // R5: condition positions enabled in mask never interrupt
    do_write(3'd4, 8'hF0);
    rt_cond[7:0] = 8'hF0;
    pulse(0, 8'hF0);
    chk("R5 condition no irq", {7'd0, irq_n}, 8'h01);
    do_read(3'd0, rd);
    chk("R5 live read", rd, 8'hF0);
    rt_cond = '0;

    // R6: event and collecting write in the same cycle
    do_write(3'd5, 8'h01);
    @(negedge clk);
    evt_pulse[8 +: 8] = 8'h01;
    bus_addr = 3'd1; bus_wdata = 8'h01; bus_wr = 1'b1;
    @(negedge clk);
    evt_pulse = '0; bus_wr = 1'b0;
    chk("R6 event kept irq", {7'd0, irq_n}, 8'h00);
    do_read(3'd1, rd);
    chk("R6 pre-clear value", rd, 8'h5E);
    do_write(3'd1, 8'h01);
    chk("R6 R8 second write clears", {7'd0, irq_n}, 8'h01);
    do_read(3'd1, rd);
    chk("R6 second collect", rd, 8'h5F);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule